// File: doc/BRIEF.md
# Mailbox Sender Register Frame

This block is the transmitting side of an inter-processor mailbox. It holds a parameterized set of 32-bit channel windows. Software on the sending processor raises bits in a window's status word by writing a mask to that window's set register; bits can only be added from this side. The receiving processor drains a window through a separate port, modelled here as one clear strobe per window that zeroes the whole status word. The status words are exported to the receiver as a flat vector.

When a window whose interrupt is enabled drains from nonzero to zero, that window's interrupt-status bit is raised. A combined status vector reports these bits, 32 windows per register. The single interrupt output is raised when any window's interrupt-status bit is set and the frame-level combined enable is on. A configuration register reports the window count. An identification register reports the revision. A request/ready pair lets software ask the receiver to wake and poll for the grant. Reads go through a simple word bus and return data one cycle after the read strobe.

Top module: `mbx_tx_frame`

## Requirements
- R1: After reset, every status word, interrupt-status bit, window interrupt enable, the wake request, the combined enable, `irq` and `rdata` are zero.
- R2: A write to window offset 0x0C (window base = index × 0x20) ORs the written mask into that window's status word. Bits already set stay set, and writing zero changes nothing. The word reads back at offset 0x00 and appears on `win_status[32*i +: 32]`.
- R3: A pulse on `rx_clr[i]` zeroes window i's status word. If a set write lands on the same window in the same cycle, the word becomes exactly the written mask.
- R4: Window offset 0x18 bit 0 is the window interrupt enable, and it reads back. Window offset 0x10 bit 0 is the interrupt status. It becomes 1 on the clock edge at which the status word goes from nonzero to zero, but only if the enable was 1 before that edge. A clear of an already-empty window does not set it.
- R5: Writing bit 0 = 1 to window offset 0x14 clears that window's interrupt status. Writing 0 there has no effect. A new drain event in the same cycle wins over the clear.
- R6: The registers at 0xFB0, 0xFB4, 0xFB8 and 0xFBC are read-only. Bit j of register k equals the interrupt status of window 32k + j. Bits for unimplemented windows read 0.
- R7: Bit 2 of 0xFA0 is the combined interrupt enable, and it reads back. `irq` is 1 exactly when this bit is 1 and at least one window interrupt status is 1.
- R8: 0xF80 reads the window count in bits 6:0. 0xFCC reads the minor revision in bits 3:0 and the major revision in bits 7:4.
- R9: Bit 0 of 0xF88 is the wake request. It drives `wake_req` and reads back. Bit 0 of 0xF8C reads the current `rx_grant` level.
- R10: The following read as zero, and writes to them change no state: offsets of windows at or above the window count, offsets not listed above, unaligned addresses (addr[1:0] ≠ 0), and the write-only offsets 0x0C and 0x14.
- R11: `rdata` holds the value of the addressed register in the cycle after `rd_en` is high, and is zero in the cycle after a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| rx_clr | input | NUM_WIN | Per-window drain strobe from the receiver |
| rx_grant | input | 1 | Receiver access grant level |
| win_status | output | 32*NUM_WIN | All status words, window i at bits 32i+31:32i |
| wake_req | output | 1 | Wake request toward the receiver |
| irq | output | 1 | Combined sender interrupt |

## Verification
A corrupted status word shows up at `win_status` on the very next cycle and in a status read one cycle after the read strobe. A missed or spurious drain event changes the window's interrupt-status read, the combined vector and `irq` in the cycle after the edge at which the drain happens. The directed tests drain windows with interrupts enabled and disabled, clear the interrupt status with a 0 and with a 1, and hit unmapped offsets. After each of these they read back every register that the stimulus could have disturbed.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;
    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int MAX_WIN = 124;
    localparam int IDX_W   = 7;

    // word offsets inside a window (addr[4:2])
    localparam logic [2:0] WO_STAT = 3'd0;
    localparam logic [2:0] WO_SET  = 3'd3;
    localparam logic [2:0] WO_IST  = 3'd4;
    localparam logic [2:0] WO_ICLR = 3'd5;
    localparam logic [2:0] WO_IEN  = 3'd6;

    // frame-level byte addresses
    localparam logic [ADDR_W-1:0] FA_WIN_END = 12'hF80;
    localparam logic [ADDR_W-1:0] FA_CFG     = 12'hF80;
    localparam logic [ADDR_W-1:0] FA_REQ     = 12'hF88;
    localparam logic [ADDR_W-1:0] FA_RDY     = 12'hF8C;
    localparam logic [ADDR_W-1:0] FA_FEN     = 12'hFA0;
    localparam logic [ADDR_W-1:0] FA_CMB0    = 12'hFB0;
    localparam logic [ADDR_W-1:0] FA_CMB1    = 12'hFB4;
    localparam logic [ADDR_W-1:0] FA_CMB2    = 12'hFB8;
    localparam logic [ADDR_W-1:0] FA_CMB3    = 12'hFBC;
    localparam logic [ADDR_W-1:0] FA_AID     = 12'hFCC;

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic              ist;
        logic              ien;
    } win_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              wake;
        logic              cmb_en;
    } frame_state_t;
endpackage

// File: rtl/mbx_tx_window.sv
module mbx_tx_window
    import mbx_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [WORD_W-1:0] set_mask,
    input  logic              ien_we,
    input  logic              ien_val,
    input  logic              iclr_we,
    input  logic              rx_clr,
    output logic [WORD_W-1:0] stat,
    output logic              ist,
    output logic              ien
);
    win_state_t cur_q, nxt_d;
    logic       drain_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.stat = (rx_clr ? '0 : cur_q.stat) | (set_we ? set_mask : '0);
        drain_d    = (cur_q.stat != '0) && (nxt_d.stat == '0) && cur_q.ien;
        if (ien_we)
            nxt_d.ien = ien_val;
        if (iclr_we)
            nxt_d.ist = 1'b0;
        if (drain_d)
            nxt_d.ist = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign stat = cur_q.stat;
    assign ist  = cur_q.ist;
    assign ien  = cur_q.ien;

    // R2: without a drain strobe no status bit is ever lost
    assert_set_keeps_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_clr |=> ((stat & $past(stat)) == $past(stat)));
    // R3: after a drain the word holds only what was set in that cycle
    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> (stat == (($past(set_we)) ? $past(set_mask) : '0)));
    // R4: interrupt rises only on an enabled nonzero-to-zero drain
    assert_ist_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ist && !$past(ist)) |-> ($past(ien) && ($past(stat) != '0) && (stat == '0)));
    // R5: a clear with no drain leaves the interrupt low
    assert_ist_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr_we && !drain_d) |=> !ist);
endmodule

// File: rtl/mbx_tx_rdmux.sv
module mbx_tx_rdmux
    import mbx_tx_pkg::*;
#(
    parameter int NUM_WIN   = 40,
    parameter int MINOR_REV = 1,
    parameter int MAJOR_REV = 1
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_WIN-1:0][WORD_W-1:0] stat,
    input  logic [NUM_WIN-1:0]             ist,
    input  logic [NUM_WIN-1:0]             ien,
    input  logic                           wake,
    input  logic                           grant,
    input  logic                           cmb_en,
    output logic [WORD_W-1:0]              rd_val
);
    localparam int CMB_BITS = 4 * WORD_W;

    logic [IDX_W-1:0]    widx;
    logic                in_win;
    logic [WORD_W-1:0]   stat_sel;
    logic                ist_sel;
    logic                ien_sel;
    logic [CMB_BITS-1:0] cmb_vec;

    always_comb begin
        widx     = addr[ADDR_W-1:5];
        in_win   = (addr < FA_WIN_END) && (int'(widx) < NUM_WIN);
        stat_sel = '0;
        ist_sel  = 1'b0;
        ien_sel  = 1'b0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (widx == IDX_W'(i)) begin
                stat_sel = stat[i];
                ist_sel  = ist[i];
                ien_sel  = ien[i];
            end
        end
        cmb_vec              = '0;
        cmb_vec[NUM_WIN-1:0] = ist;

        rd_val = '0;
        if (addr[1:0] == 2'b00) begin
            if (in_win) begin
                case (addr[4:2])
                    WO_STAT: rd_val = stat_sel;
                    WO_IST:  rd_val = {{(WORD_W-1){1'b0}}, ist_sel};
                    WO_IEN:  rd_val = {{(WORD_W-1){1'b0}}, ien_sel};
                    default: rd_val = '0;
                endcase
            end else begin
                case (addr)
                    FA_CFG:  rd_val = {{(WORD_W-7){1'b0}}, 7'(NUM_WIN)};
                    FA_REQ:  rd_val = {{(WORD_W-1){1'b0}}, wake};
                    FA_RDY:  rd_val = {{(WORD_W-1){1'b0}}, grant};
                    FA_FEN:  rd_val = {{(WORD_W-3){1'b0}}, cmb_en, 2'b00};
                    FA_CMB0: rd_val = cmb_vec[0*WORD_W +: WORD_W];
                    FA_CMB1: rd_val = cmb_vec[1*WORD_W +: WORD_W];
                    FA_CMB2: rd_val = cmb_vec[2*WORD_W +: WORD_W];
                    FA_CMB3: rd_val = cmb_vec[3*WORD_W +: WORD_W];
                    FA_AID:  rd_val = {{(WORD_W-8){1'b0}}, 4'(MAJOR_REV), 4'(MINOR_REV)};
                    default: rd_val = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_tx_frame.sv
module mbx_tx_frame
    import mbx_tx_pkg::*;
#(
    parameter int NUM_WIN   = 40,
    parameter int MINOR_REV = 1,
    parameter int MAJOR_REV = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [11:0]               addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    input  logic [NUM_WIN-1:0]        rx_clr,
    input  logic                      rx_grant,
    output logic [32*NUM_WIN-1:0]     win_status,
    output logic                      wake_req,
    output logic                      irq
);
    localparam int STAT_BITS = WORD_W * NUM_WIN;

    logic [NUM_WIN-1:0][WORD_W-1:0] stat_w;
    logic [NUM_WIN-1:0]             ist_w;
    logic [NUM_WIN-1:0]             ien_w;
    logic [WORD_W-1:0]              rd_val;
    logic                           wr_ok;
    logic                           win_range;
    frame_state_t                   cur_q, nxt_d;

    assign wr_ok     = wr_en && (addr[1:0] == 2'b00);
    assign win_range = (addr < FA_WIN_END);

    generate
        for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
            logic hit;
            assign hit = wr_ok && win_range && (addr[ADDR_W-1:5] == IDX_W'(i));
            mbx_tx_window u_win (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_we   (hit && (addr[4:2] == WO_SET)),
                .set_mask (wdata),
                .ien_we   (hit && (addr[4:2] == WO_IEN)),
                .ien_val  (wdata[0]),
                .iclr_we  (hit && (addr[4:2] == WO_ICLR) && wdata[0]),
                .rx_clr   (rx_clr[i]),
                .stat     (stat_w[i]),
                .ist      (ist_w[i]),
                .ien      (ien_w[i])
            );
        end
    endgenerate

    mbx_tx_rdmux #(
        .NUM_WIN   (NUM_WIN),
        .MINOR_REV (MINOR_REV),
        .MAJOR_REV (MAJOR_REV)
    ) u_rdmux (
        .addr   (addr),
        .stat   (stat_w),
        .ist    (ist_w),
        .ien    (ien_w),
        .wake   (cur_q.wake),
        .grant  (rx_grant),
        .cmb_en (cur_q.cmb_en),
        .rd_val (rd_val)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.rdata = rd_en ? rd_val : '0;
        if (wr_ok && (addr == FA_REQ))
            nxt_d.wake = wdata[0];
        if (wr_ok && (addr == FA_FEN))
            nxt_d.cmb_en = wdata[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign rdata      = cur_q.rdata;
    assign wake_req   = cur_q.wake;
    assign win_status = STAT_BITS'(stat_w);
    assign irq        = cur_q.cmb_en && (ist_w != '0);

    // R9: a request write lands on the wake output one cycle later
    assert_wake_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == FA_REQ)) |=> (wake_req == $past(wdata[0])));
    // R11: no read strobe, no read data
    assert_rdata_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
    // R7: turning the combined enable off silences the interrupt
    assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == FA_FEN) && !wdata[2]) |=> !irq);
endmodule

// File: tb/test_mbx_tx_frame.sv
module test_mbx_tx_frame;
    localparam int NW = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [NW-1:0]     rx_clr = '0;
    logic              rx_grant = 1'b0;
    logic [32*NW-1:0]  win_status;
    logic              wake_req;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mbx_tx_frame #(.NUM_WIN(NW), .MINOR_REV(1), .MAJOR_REV(1)) i_mbx_tx_frame (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_clr(rx_clr), .rx_grant(rx_grant),
        .win_status(win_status), .wake_req(wake_req), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic drain(input int w);
        @(negedge clk);
        rx_clr[w] = 1'b1;
        @(negedge clk);
        rx_clr[w] = 1'b0;
    endtask

    function automatic logic [11:0] wa(input int w, input int ofs);
        return 12'(w * 32 + ofs);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 win_status", 32'(win_status != '0), 0);
        chk("R1 wake_req", 32'(wake_req), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rdata", rdata, 0);
        rd(wa(0, 'h18), v); chk("R1 ien", v, 0);
        rd(wa(0, 'h10), v); chk("R1 ist", v, 0);
        rd(12'hFA0, v); chk("R1 cmb_en", v, 0);
    endtask

    task automatic t_set();
        logic [31:0] v;
        wr(wa(0, 'h0C), 32'h0000_000F);
        rd(wa(0, 0), v); chk("R2 first set", v, 32'h0F);
        wr(wa(0, 'h0C), 32'h0000_00F0);
        rd(wa(0, 0), v); chk("R2 or set", v, 32'hFF);
        wr(wa(0, 'h0C), 32'h0);
        rd(wa(0, 0), v); chk("R2 zero set", v, 32'hFF);
        chk("R2 port", win_status[31:0], 32'hFF);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        drain(0);
        chk("R3 drained", win_status[31:0], 0);
        wr(wa(0, 'h0C), 32'h5);
        @(negedge clk);
        wr_en = 1'b1; addr = wa(0, 'h0C); wdata = 32'hA0; rx_clr[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rx_clr[0] = 1'b0;
        rd(wa(0, 0), v); chk("R3 set+clr same cycle", v, 32'hA0);
        drain(0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        wr(wa(1, 'h0C), 32'h1);
        drain(1);
        rd(wa(1, 'h10), v); chk("R4 disabled no ist", v, 0);
        wr(wa(1, 'h18), 32'h1);
        rd(wa(1, 'h18), v); chk("R4 ien readback", v, 1);
        wr(wa(1, 'h0C), 32'h3);
        drain(1);
        rd(wa(1, 'h10), v); chk("R4 drain sets ist", v, 1);
        wr(wa(2, 'h18), 32'h1);
        drain(2);
        rd(wa(2, 'h10), v); chk("R4 empty drain no ist", v, 0);
    endtask

    task automatic t_intclr();
        logic [31:0] v;
        wr(wa(1, 'h14), 32'h0);
        rd(wa(1, 'h10), v); chk("R5 zero write keeps", v, 1);
        wr(wa(1, 'h14), 32'h1);
        rd(wa(1, 'h10), v); chk("R5 one write clears", v, 0);
    endtask

    task automatic t_comb();
        logic [31:0] v;
        wr(wa(35, 'h18), 32'h1);
        wr(wa(35, 'h0C), 32'h8000_0000);
        drain(35);
        rd(12'hFB4, v); chk("R6 comb reg1", v, 32'h8);
        rd(12'hFB0, v); chk("R6 comb reg0", v, 0);
        rd(12'hFB8, v); chk("R6 comb reg2", v, 0);
    endtask

    task automatic t_irqout();
        logic [31:0] v;
        chk("R7 irq off when disabled", 32'(irq), 0);
        wr(12'hFA0, 32'h4);
        chk("R7 irq on", 32'(irq), 1);
        rd(12'hFA0, v); chk("R7 fen readback", v, 4);
        wr(wa(35, 'h14), 32'h1);
        chk("R7 irq off after clear", 32'(irq), 0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        rd(12'hF80, v); chk("R8 window count", v, NW);
        rd(12'hFCC, v); chk("R8 revision", v, 32'h11);
    endtask

    task automatic t_access();
        logic [31:0] v;
        wr(12'hF88, 32'h1);
        chk("R9 wake_req", 32'(wake_req), 1);
        rd(12'hF88, v); chk("R9 req readback", v, 1);
        rd(12'hF8C, v); chk("R9 not granted", v, 0);
        rx_grant = 1'b1;
        rd(12'hF8C, v); chk("R9 granted", v, 1);
        wr(12'hF88, 32'h0);
        chk("R9 wake drop", 32'(wake_req), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        logic [32*NW-1:0] snap;
        snap = win_status;
        wr(wa(NW, 'h0C), 32'hFFFF_FFFF);
        wr(12'hF84, 32'hFFFF_FFFF);
        wr(wa(3, 'h0D), 32'hFFFF_FFFF);
        chk("R10 status untouched", 32'(win_status != snap), 0);
        rd(wa(NW, 0), v); chk("R10 window past count", v, 0);
        rd(12'hF84, v); chk("R10 reserved", v, 0);
        rd(wa(0, 'h0C), v); chk("R10 set reads zero", v, 0);
        rd(wa(0, 'h14), v); chk("R10 iclr reads zero", v, 0);
        rd(12'hF81, v); chk("R10 unaligned", v, 0);
    endtask

    task automatic t_rdtiming();
        logic [31:0] v;
        wr(wa(4, 'h0C), 32'h1234);
        rd(wa(4, 0), v); chk("R11 data next cycle", v, 32'h1234);
        @(negedge clk);
        chk("R11 idle zero", rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set();
        t_clear();
        t_irq();
        t_intclr();
        t_comb();
        t_irqout();
        t_id();
        t_access();
        t_unmapped();
        t_rdtiming();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule